// File: doc/BRIEF.md
# Timed Command List Sequencer

This block holds a short programmable list of outgoing command items for a single link and plays them out in order once it is triggered. Each list entry carries a command word, a lane bitmap and a relative delay. The delay is counted in bunch-clock ticks from the issue of the previous entry. For the first entry it is counted from the trigger. An issued command is presented for one cycle on the command output, and a per-lane strobe vector copies the entry's bitmap, so that only the selected lane encoders take the item.

Playback starts from entry 0 on either of two triggers. One is a chosen bit of the timing-system user-bit vector, picked by a parameter. The other is a one-cycle start pulse from the host. Playback ends on the entry that carries the final flag, or after the last storage slot. A trigger that arrives while a playback is running does not restart it. Such a trigger only increments a saturating overrun count. The list can be loaded only while the sequencer is idle.

The controller has three states. `S_IDLE` waits for a trigger. `S_WAIT` counts down the delay of the entry that is due. `S_EMIT` issues that entry. The transitions are as follows:
- trigger taken: from `S_IDLE` to `S_EMIT` when entry 0 has delay 0, otherwise to `S_WAIT`
- count done: from `S_WAIT` to `S_EMIT`
- chain: from `S_EMIT` to `S_EMIT` when the next entry has delay 0, otherwise to `S_WAIT`
- finish: from `S_EMIT` to `S_IDLE` on the final flag or the last slot

Top module: `cmdseq_top`

## Requirements
- R1: After reset the sequencer is idle, `busy`, `cmd_valid`, `wr_reject` and `lane_strobe` are low, `overrun_cnt` is 0, and every list entry holds delay 0, command 0, bitmap 0 and a cleared final flag.
- R2: A write in an idle cycle with no trigger present stores `wr_cmd`, `wr_mask`, `wr_dly` and `wr_last` into the entry at `wr_addr`. The stored values are the ones that a later playback issues.
- R3: A write in a cycle where `busy` is high, or where a trigger is present, is not stored, and `wr_reject` is high for exactly the following cycle.
- R4: In an idle cycle, `ttc_user[USER_BIT]` high is a trigger (default bit 2 of 4). The other user bits have no effect.
- R5: In an idle cycle, `host_go` high is a trigger. Playback always starts at entry 0.
- R6: Entry k is issued d+1 cycles after the cycle in which entry k-1 was issued, where d is its 16-bit delay. Entry 0 is issued d+1 cycles after the trigger cycle, so a delay of 0 means the next cycle.
- R7: In an issue cycle `cmd_valid` is high, `cmd_data` is the entry's command and `lane_strobe` equals its lane bitmap. In all other cycles the three outputs are 0.
- R8: The cycle after an entry with the final flag is issued, or after entry DEPTH-1 is issued, the sequencer is idle.
- R9: A trigger in a cycle where `busy` is high is ignored and increments `overrun_cnt` by one, saturating at all ones. Both triggers in the same cycle count once.
- R10: `busy` is high from the cycle after the trigger through the cycle of the final issue, and it is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ttc_user | input | UB_W (4) | Timing-system user bits |
| host_go | input | 1 | Host start pulse |
| wr_en | input | 1 | List write strobe |
| wr_addr | input | $clog2(DEPTH) (4) | Entry index to write |
| wr_cmd | input | CMD_W (8) | Command word to store |
| wr_mask | input | LANES (8) | Lane bitmap to store |
| wr_dly | input | DLY_W (16) | Relative delay to store |
| wr_last | input | 1 | Final-entry flag to store |
| wr_reject | output | 1 | Previous-cycle write was refused |
| busy | output | 1 | Playback in progress |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_data | output | CMD_W (8) | Issued command word |
| lane_strobe | output | LANES (8) | Per-lane issue strobe |
| overrun_cnt | output | OVR_W (4) | Ignored-trigger count, saturating |

## Verification
The assertions check a set of properties on every cycle:
- a locked list slot keeps its value
- a busy trigger either advances the overrun count or leaves it at saturation, and in other cycles the count holds
- the finish transition returns to idle
- a zero delay chains one issue to the next
- a running countdown stays in the wait state
- an idle trigger always leaves idle
- an issue only happens while busy

Only the bench scenarios show issue times that add up across a whole list, together with the correct command and bitmap per entry. The same applies to rejected writes leaving the list untouched at the next playback, the wrap after the last slot, and the saturation value reached after many overruns. These are compared each cycle against a behavioural model.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WAIT = 2'd1,
        S_EMIT = 2'd2
    } seq_state_e;
endpackage

// File: rtl/cmdseq_store.sv
module cmdseq_store #(
    parameter int DEPTH = 16,
    parameter int CMD_W = 8,
    parameter int LANES = 8,
    parameter int DLY_W = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [CMD_W-1:0] wr_cmd,
    input  logic [LANES-1:0] wr_mask,
    input  logic [DLY_W-1:0] wr_dly,
    input  logic             wr_last,
    input  logic             lock,
    output logic             wr_reject,
    input  logic [AW-1:0]    rd_addr,
    output logic [CMD_W-1:0] rd_cmd,
    output logic [LANES-1:0] rd_mask,
    output logic [DLY_W-1:0] rd_dly,
    output logic             rd_last,
    input  logic [AW-1:0]    nx_addr,
    output logic [DLY_W-1:0] nx_dly
);
    logic [CMD_W-1:0] cmd_q  [DEPTH];
    logic [LANES-1:0] mask_q [DEPTH];
    logic [DLY_W-1:0] dly_q  [DEPTH];
    logic [DEPTH-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cmd_q[i]  <= '0;
                mask_q[i] <= '0;
                dly_q[i]  <= '0;
            end
            last_q    <= '0;
            wr_reject <= 1'b0;
        end else begin
            wr_reject <= wr_en && lock;
            if (wr_en && !lock) begin
                cmd_q[wr_addr]  <= wr_cmd;
                mask_q[wr_addr] <= wr_mask;
                dly_q[wr_addr]  <= wr_dly;
                last_q[wr_addr] <= wr_last;
            end
        end
    end

    assign rd_cmd  = cmd_q[rd_addr];
    assign rd_mask = mask_q[rd_addr];
    assign rd_dly  = dly_q[rd_addr];
    assign rd_last = last_q[rd_addr];
    assign nx_dly  = dly_q[nx_addr];

    // R3: a locked slot keeps its content
    p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && wr_en) |=> (cmd_q[$past(wr_addr)] == $past(cmd_q[wr_addr])
                             && dly_q[$past(wr_addr)] == $past(dly_q[wr_addr])));
endmodule

// File: rtl/cmdseq_trigger.sv
module cmdseq_trigger #(
    parameter int UB_W     = 4,
    parameter int USER_BIT = 2,
    parameter int OVR_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [UB_W-1:0]  ttc_user,
    input  logic             host_go,
    input  logic             busy,
    output logic             trig,
    output logic [OVR_W-1:0] overrun_cnt
);
    localparam logic [OVR_W-1:0] OVR_MAX = '1;

    assign trig = ttc_user[USER_BIT] | host_go;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            overrun_cnt <= '0;
        else if (trig && busy && overrun_cnt != OVR_MAX)
            overrun_cnt <= overrun_cnt + 1'b1;
    end

    // R9: busy trigger advances the count unless saturated
    p_overrun_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && busy && overrun_cnt != OVR_MAX) |=>
            (overrun_cnt == $past(overrun_cnt) + 1'b1));
    // R9: no busy trigger, count holds
    p_overrun_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(trig && busy) |=> $stable(overrun_cnt));
endmodule

// File: rtl/cmdseq_ctrl.sv
module cmdseq_ctrl
    import cmdseq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DLY_W = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [DLY_W-1:0] rd_dly,
    input  logic             rd_last,
    input  logic [DLY_W-1:0] nx_dly,
    output logic [AW-1:0]    rd_addr,
    output logic [AW-1:0]    nx_addr,
    output logic             emit,
    output logic             busy
);
    localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

    seq_state_e       state_q, state_d;
    logic [AW-1:0]    ptr_q, ptr_d;
    logic [DLY_W-1:0] cnt_q, cnt_d;
    logic             finish;

    assign nx_addr = (ptr_q == LAST_SLOT) ? '0 : ptr_q + 1'b1;
    assign finish  = rd_last || (ptr_q == LAST_SLOT);

    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            S_IDLE: if (trig) begin
                ptr_d = '0;
                if (rd_dly == '0) state_d = S_EMIT;
                else begin
                    state_d = S_WAIT;
                    cnt_d   = rd_dly - 1'b1;
                end
            end
            S_WAIT: begin
                if (cnt_q == '0) state_d = S_EMIT;
                else             cnt_d   = cnt_q - 1'b1;
            end
            S_EMIT: begin
                if (finish) begin
                    state_d = S_IDLE;
                    ptr_d   = '0;
                end else begin
                    ptr_d = nx_addr;
                    if (nx_dly == '0) state_d = S_EMIT;
                    else begin
                        state_d = S_WAIT;
                        cnt_d   = nx_dly - 1'b1;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ptr_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        rd_addr = ptr_q;
        emit    = (state_q == S_EMIT);
        busy    = (state_q != S_IDLE);
    end

    // R8: finish transition returns to idle
    p_finish_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EMIT && finish) |=> (state_q == S_IDLE));
    // R6: zero delay chains straight into the next issue
    p_zero_chain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EMIT && !finish && nx_dly == '0) |=> (state_q == S_EMIT));
    // R6: running countdown stays waiting
    p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && cnt_q != '0) |=> (state_q == S_WAIT));
    // R10: an idle trigger always leaves idle
    p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && trig) |=> busy);
endmodule

// File: rtl/cmdseq_top.sv
module cmdseq_top #(
    parameter int DEPTH    = 16,
    parameter int CMD_W    = 8,
    parameter int LANES    = 8,
    parameter int DLY_W    = 16,
    parameter int UB_W     = 4,
    parameter int USER_BIT = 2,
    parameter int OVR_W    = 4,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [UB_W-1:0]  ttc_user,
    input  logic             host_go,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [CMD_W-1:0] wr_cmd,
    input  logic [LANES-1:0] wr_mask,
    input  logic [DLY_W-1:0] wr_dly,
    input  logic             wr_last,
    output logic             wr_reject,
    output logic             busy,
    output logic             cmd_valid,
    output logic [CMD_W-1:0] cmd_data,
    output logic [LANES-1:0] lane_strobe,
    output logic [OVR_W-1:0] overrun_cnt
);
    logic             trig, emit;
    logic [AW-1:0]    rd_addr, nx_addr;
    logic [CMD_W-1:0] rd_cmd;
    logic [LANES-1:0] rd_mask;
    logic [DLY_W-1:0] rd_dly, nx_dly;
    logic             rd_last;

    cmdseq_trigger #(.UB_W(UB_W), .USER_BIT(USER_BIT), .OVR_W(OVR_W)) u_trig (
        .clk(clk), .rst_n(rst_n), .ttc_user(ttc_user), .host_go(host_go),
        .busy(busy), .trig(trig), .overrun_cnt(overrun_cnt));

    cmdseq_store #(.DEPTH(DEPTH), .CMD_W(CMD_W), .LANES(LANES), .DLY_W(DLY_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_cmd(wr_cmd), .wr_mask(wr_mask), .wr_dly(wr_dly), .wr_last(wr_last),
        .lock(busy || trig), .wr_reject(wr_reject),
        .rd_addr(rd_addr), .rd_cmd(rd_cmd), .rd_mask(rd_mask), .rd_dly(rd_dly),
        .rd_last(rd_last), .nx_addr(nx_addr), .nx_dly(nx_dly));

    cmdseq_ctrl #(.DEPTH(DEPTH), .DLY_W(DLY_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .trig(trig), .rd_dly(rd_dly), .rd_last(rd_last),
        .nx_dly(nx_dly), .rd_addr(rd_addr), .nx_addr(nx_addr), .emit(emit), .busy(busy));

    assign cmd_valid   = emit;
    assign cmd_data    = emit ? rd_cmd  : '0;
    assign lane_strobe = emit ? rd_mask : '0;

    // R10: an issue only happens while busy
    p_issue_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> busy);
endmodule

// File: tb/tb_cmdseq_top.sv
module tb_cmdseq_top;
    localparam int DEPTH = 16;
    localparam int UBIT  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ttc_user = '0;
    logic        host_go = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_cmd = '0;
    logic [7:0]  wr_mask = '0;
    logic [15:0] wr_dly = '0;
    logic        wr_last = 1'b0;
    logic        wr_reject, busy, cmd_valid;
    logic [7:0]  cmd_data, lane_strobe;
    logic [3:0]  overrun_cnt;

    int n_cmp = 0, n_bad = 0;
    bit run_cmp = 0, done = 0;

    cmdseq_top dut (.*);

    always #10 clk = ~clk;

    // behavioural model
    int m_cmd[DEPTH], m_mask[DEPTH], m_dly[DEPTH], m_last[DEPTH];
    int m_busy, m_idx, m_wait, m_ovr, e_rej;
    bit trg;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                m_cmd[i] = 0; m_mask[i] = 0; m_dly[i] = 0; m_last[i] = 0;
            end
            m_busy = 0; m_idx = 0; m_wait = 0; m_ovr = 0; e_rej = 0;
        end else begin
            trg   = host_go || ttc_user[UBIT];
            e_rej = 0;
            if (m_busy != 0) begin
                if (trg && m_ovr < 15) m_ovr++;
                if (wr_en) e_rej = 1;
                if (m_wait == 0) begin
                    if (m_last[m_idx] != 0 || m_idx == DEPTH - 1) m_busy = 0;
                    else begin m_idx++; m_wait = m_dly[m_idx]; end
                end else m_wait--;
            end else if (trg) begin
                m_busy = 1; m_idx = 0; m_wait = m_dly[0];
                if (wr_en) e_rej = 1;
            end else if (wr_en) begin
                m_cmd[wr_addr] = wr_cmd; m_mask[wr_addr] = wr_mask;
                m_dly[wr_addr] = wr_dly; m_last[wr_addr] = wr_last;
            end
        end
    end

    task automatic check(input int act, input int exp, input string tag);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (run_cmp) begin
            int ev;
            ev = (m_busy != 0 && m_wait == 0) ? 1 : 0;
            check(cmd_valid, ev, "R6");
            check(cmd_data, ev != 0 ? m_cmd[m_idx] : 0, "R7");
            check(lane_strobe, ev != 0 ? m_mask[m_idx] : 0, "R7");
            check(busy, m_busy, "R10");
            check(wr_reject, e_rej, "R3");
            check(overrun_cnt, m_ovr, "R9");
        end
    end

    task automatic wr(input int a, input int c, input int m, input int d, input int l);
        @(negedge clk);
        wr_en = 1; wr_addr = 4'(a); wr_cmd = 8'(c); wr_mask = 8'(m);
        wr_dly = 16'(d); wr_last = l[0];
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_host();
        @(negedge clk); host_go = 1;
        @(negedge clk); host_go = 0;
    endtask

    task automatic pulse_ttc(input logic [3:0] b);
        @(negedge clk); ttc_user = b;
        @(negedge clk); ttc_user = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check(busy, 0, "R1");
        check(cmd_valid, 0, "R1");
        check(lane_strobe, 0, "R1");
        check(overrun_cnt, 0, "R1");
        check(wr_reject, 0, "R1");
        run_cmp = 1;

        // R2: load a five-entry list
        wr(0, 'hA1, 'h03, 0, 0);
        wr(1, 'hB2, 'h10, 3, 0);
        wr(2, 'hC3, 'hFF, 0, 0);
        wr(3, 'hD4, 'h81, 1, 0);
        wr(4, 'hE5, 'h40, 2, 1);

        // R5: host start, entry 0 with delay 0 issues next cycle
        pulse_host();
        check(busy, 1, "R5");
        check(cmd_data, 'hA1, "R2");
        idle(15);
        check(busy, 0, "R8");

        // R4: a non-selected user bit does nothing
        pulse_ttc(4'b0001);
        check(busy, 0, "R4");
        pulse_ttc(4'b0100);
        check(busy, 1, "R4");
        // R3: write during playback is refused
        wr(1, 'h55, 'h55, 0, 1);
        // R9: busy triggers, both at once count once
        @(negedge clk); host_go = 1; ttc_user = 4'b0100;
        @(negedge clk); host_go = 0; ttc_user = '0;
        idle(15);
        // R3: list unchanged, replay compared by the model
        pulse_host();
        idle(15);

        // R3: write together with an idle trigger is refused
        @(negedge clk); host_go = 1; wr_en = 1; wr_addr = 0; wr_cmd = 'h77; wr_dly = 5;
        @(negedge clk); host_go = 0; wr_en = 0;
        idle(15);

        // R9: saturation during a long delay
        wr(0, 'h99, 'h0F, 40, 1);
        pulse_host();
        for (int i = 0; i < 20; i++) pulse_host();
        check(overrun_cnt, 15, "R9");
        idle(45);

        // R8: no final flag, playback wraps off the last slot
        for (int i = 0; i < DEPTH; i++) wr(i, 16 + i, 1 << (i % 8), 1, 0);
        pulse_ttc(4'b0100);
        idle(40);
        check(busy, 0, "R8");

        run_cmp = 0;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule